// File: doc/BRIEF.md
# Dual Accumulator Multiply-Accumulate Unit

This block is a single-cycle multiply-accumulate datapath with two independent 40-bit accumulators. Each 40-bit accumulator holds a 32-bit result range plus 8 guard bits. On every clock edge it takes two 16-bit operands and an operation code, and updates the accumulator named by the select input. The operation may load the product, add the product to the accumulator, or subtract the product from it. Two other operations clear the accumulator or clamp it to the 32-bit signed range. Each operand carries its own signed/unsigned flag. A fractional mode doubles the product before it is used.

The read side is combinational from the stored state. The accumulator named by the select input appears on the output together with two flags. The overflow flag shows that the stored value has left the 32-bit signed range. The saturation flag records that a clamp changed the value. An operation therefore shows its result just after the clock edge on which it was presented. The other accumulator can be read by presenting a no-operation code with the other select value.

Top module: `dual_acc_mac`

## Requirements
- R1: While reset is high at a clock edge, both accumulators become zero and both saturation flags become 0. After that edge acc_o is 0 and ovf_o and sat_o are 0 for either select value.
- R2: Operation code 1 (load) writes the product of the operands, sign-extended to 40 bits, into the selected accumulator. An operand is taken as two's complement when its signed flag is 1 and as an unsigned number when its flag is 0.
- R3: Operation code 2 adds the product to the selected accumulator. Operation code 3 subtracts the product from it. Both results wrap modulo 2^40.
- R4: When frac_i is 1, the product is multiplied by two before it is loaded, added or subtracted.
- R5: An operation changes only the accumulator named by acc_sel_i (0 or 1). The other accumulator and its saturation flag keep their values.
- R6: Operation code 4 sets the selected accumulator to zero and clears its saturation flag.
- R7: ovf_o is 1 exactly when acc_o, read as a 40-bit two's complement number, lies outside the range -2^31 to 2^31-1.
- R8: Operation code 5 clamps the selected accumulator. A value above 2^31-1 becomes 0x007FFFFFFF. A value below -2^31 becomes 0xFF80000000. In both cases the saturation flag is set. A value already in range is left unchanged and so is its flag.
- R9: The saturation flag of an accumulator is cleared by a load (code 1) or a clear (code 4). An add or subtract (codes 2 and 3) leaves it as it was.
- R10: Operation codes 0, 6 and 7 change neither accumulator nor either saturation flag.
- R11: acc_o, ovf_o and sat_o show the state of the accumulator chosen by acc_sel_i in the same cycle, with no register in the read path. The result of an operation is visible right after the edge that performs it.
- R12: Each operation completes in a single clock cycle, so back-to-back operations on the same accumulator chain with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code: 0 none, 1 load, 2 add, 3 subtract, 4 clear, 5 clamp, 6 and 7 none |
| acc_sel_i | input | 1 | Accumulator to operate on and to read out |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| a_signed_i | input | 1 | 1: a_i is two's complement, 0: unsigned |
| b_signed_i | input | 1 | 1: b_i is two's complement, 0: unsigned |
| frac_i | input | 1 | 1: double the product (fractional format) |
| acc_o | output | 40 | Value of the selected accumulator |
| ovf_o | output | 1 | Selected accumulator is outside the 32-bit signed range |
| sat_o | output | 1 | Saturation flag of the selected accumulator |

## Verification
The bench targets the extreme products. 0xFFFF times 0xFFFF unsigned overflows the 32-bit range, a signed-by-unsigned mix yields -65535, and 0x8000 squared in fractional mode lands exactly on 2^31. A design that drops the per-operand sign extension or the fractional shift shows a wrong value or a wrong overflow flag on these. The bench clamps in both directions and also clamps an in-range value. This exposes a clamp that picks the wrong limit or sets the flag when nothing changed. Long chains of adds drive the accumulator past 2^39, which exposes a design that saturates or truncates the guard bits instead of wrapping. Independence is probed by reading the idle accumulator after work on the other one. Codes 6 and 7 are presented to catch a decoder that treats them as a live operation.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int MAC_OP_W    = 16;
    localparam int MAC_GUARD_W = 8;
    localparam int MAC_N_ACC   = 2;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LOAD = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_CLR  = 3'd4,
        OP_CLMP = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } mac_op_e;

    typedef struct packed {
        logic a_sgn;
        logic b_sgn;
        logic frac;
    } mac_mode_t;

endpackage

// File: rtl/mac_range_check.sv
module mac_range_check #(
    parameter int ACC_W  = 40,
    parameter int CORE_W = 32
) (
    input  logic [ACC_W-1:0] value_i,
    output logic             out_of_range_o
);
    localparam int TOP_W = ACC_W - CORE_W + 1;

    logic [TOP_W-1:0] top_bits;

    // Guard bits plus the core sign bit must all agree for an in-range value.
    assign top_bits       = value_i[ACC_W-1:CORE_W-1];
    assign out_of_range_o = !((&top_bits) || !(|top_bits));
endmodule

// File: rtl/mac_multiplier.sv
module mac_multiplier
    import mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    input  mac_mode_t        mode_i,
    output logic [ACC_W-1:0] prod_o
);
    localparam int EXT_W  = OP_W + 1;
    localparam int PROD_W = 2 * EXT_W;
    localparam int PAD_W  = ACC_W - PROD_W;

    logic signed [EXT_W-1:0]  a_ext;
    logic signed [EXT_W-1:0]  b_ext;
    logic signed [PROD_W-1:0] prod_raw;
    logic        [ACC_W-1:0]  prod_wide;

    // One extra bit per operand lets a single signed multiplier serve both
    // signed and unsigned operand formats.
    assign a_ext     = $signed({mode_i.a_sgn & a_i[OP_W-1], a_i});
    assign b_ext     = $signed({mode_i.b_sgn & b_i[OP_W-1], b_i});
    assign prod_raw  = a_ext * b_ext;
    assign prod_wide = {{PAD_W{prod_raw[PROD_W-1]}}, prod_raw};
    assign prod_o    = mode_i.frac ? {prod_wide[ACC_W-2:0], 1'b0} : prod_wide;
endmodule

// File: rtl/mac_next_value.sv
module mac_next_value
    import mac_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int CORE_W = 32
) (
    input  mac_op_e          op_i,
    input  logic [ACC_W-1:0] cur_i,
    input  logic             cur_sat_i,
    input  logic [ACC_W-1:0] prod_i,
    output logic [ACC_W-1:0] nxt_o,
    output logic             nxt_sat_o
);
    localparam int HI_W = ACC_W - CORE_W + 1;
    localparam logic [ACC_W-1:0] POS_LIM = {{HI_W{1'b0}}, {(CORE_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIM = {{HI_W{1'b1}}, {(CORE_W-1){1'b0}}};

    logic cur_oor;

    mac_range_check #(.ACC_W(ACC_W), .CORE_W(CORE_W)) u_range (
        .value_i        (cur_i),
        .out_of_range_o (cur_oor)
    );

    always_comb begin
        nxt_o     = cur_i;
        nxt_sat_o = cur_sat_i;
        case (op_i)
            OP_LOAD: begin
                nxt_o     = prod_i;
                nxt_sat_o = 1'b0;
            end
            OP_ADD:  nxt_o = cur_i + prod_i;
            OP_SUB:  nxt_o = cur_i - prod_i;
            OP_CLR: begin
                nxt_o     = '0;
                nxt_sat_o = 1'b0;
            end
            OP_CLMP: begin
                if (cur_oor) begin
                    nxt_o     = cur_i[ACC_W-1] ? NEG_LIM : POS_LIM;
                    nxt_sat_o = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dual_acc_mac.sv
module dual_acc_mac
    import mac_pkg::*;
#(
    parameter int OP_W    = MAC_OP_W,
    parameter int GUARD_W = MAC_GUARD_W,
    parameter int N_ACC   = MAC_N_ACC,
    localparam int ACC_W  = 2 * OP_W + GUARD_W,
    localparam int CORE_W = 2 * OP_W,
    localparam int SEL_W  = (N_ACC > 1) ? $clog2(N_ACC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_i,
    input  logic [SEL_W-1:0] acc_sel_i,
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    input  logic             a_signed_i,
    input  logic             b_signed_i,
    input  logic             frac_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             ovf_o,
    output logic             sat_o
);
    mac_op_e                       op;
    mac_mode_t                     mode;
    logic [ACC_W-1:0]              prod;
    logic [N_ACC-1:0][ACC_W-1:0]   acc_q;
    logic [N_ACC-1:0]              sat_q;

    assign op   = mac_op_e'(op_i);
    assign mode = '{a_sgn: a_signed_i, b_sgn: b_signed_i, frac: frac_i};

    mac_multiplier #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
        .a_i    (a_i),
        .b_i    (b_i),
        .mode_i (mode),
        .prod_o (prod)
    );

    for (genvar g = 0; g < N_ACC; g++) begin : g_acc
        logic [ACC_W-1:0] nxt;
        logic             nxt_sat;

        mac_next_value #(.ACC_W(ACC_W), .CORE_W(CORE_W)) u_next (
            .op_i      (op),
            .cur_i     (acc_q[g]),
            .cur_sat_i (sat_q[g]),
            .prod_i    (prod),
            .nxt_o     (nxt),
            .nxt_sat_o (nxt_sat)
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[g] <= '0;
                sat_q[g] <= 1'b0;
            end else if (acc_sel_i == SEL_W'(g)) begin
                acc_q[g] <= nxt;
                sat_q[g] <= nxt_sat;
            end
        end
    end

    assign acc_o = acc_q[acc_sel_i];
    assign sat_o = sat_q[acc_sel_i];

    mac_range_check #(.ACC_W(ACC_W), .CORE_W(CORE_W)) u_ovf (
        .value_i        (acc_o),
        .out_of_range_o (ovf_o)
    );
endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
    parameter int ACC_W  = 40,
    parameter int CORE_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       op_i,
    input logic             acc_sel_i,
    input logic [ACC_W-1:0] acc0,
    input logic [ACC_W-1:0] acc1,
    input logic             sat0,
    input logic             sat1
);
    localparam int HI_W   = ACC_W - CORE_W + 1;
    localparam int PROD_W = CORE_W + 2;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (acc0 == '0 && acc1 == '0 && !sat0 && !sat1));

    p_load_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd1 && acc_sel_i == 1'b0)
        |=> ((&acc0[ACC_W-1:PROD_W-1]) || !(|acc0[ACC_W-1:PROD_W-1])));

    p_other_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_sel_i == 1'b0) |=> ($stable(acc1) && $stable(sat1)));

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd4 && acc_sel_i == 1'b1) |=> (acc1 == '0 && !sat1));

    p_clamp_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd5 && acc_sel_i == 1'b0)
        |=> ((&acc0[ACC_W-1:CORE_W-1]) || !(|acc0[ACC_W-1:HI_W-1+CORE_W-HI_W])));

    p_sat_source_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(sat0) |-> $past(op_i == 3'd5 && acc_sel_i == 1'b0));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0 || op_i == 3'd6 || op_i == 3'd7)
        |=> ($stable(acc0) && $stable(acc1) && $stable(sat0) && $stable(sat1)));
endmodule

bind dual_acc_mac mac_checker #(.ACC_W(ACC_W), .CORE_W(CORE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op_i),
    .acc_sel_i (acc_sel_i),
    .acc0      (acc_q[0]),
    .acc1      (acc_q[1]),
    .sat0      (sat_q[0]),
    .sat1      (sat_q[1])
);

// File: tb/dual_acc_mac_bench.sv
module dual_acc_mac_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op_i;
    logic        acc_sel_i;
    logic [15:0] a_i, b_i;
    logic        a_signed_i, b_signed_i, frac_i;
    logic [39:0] acc_o;
    logic        ovf_o, sat_o;

    int checks = 0;
    int errors = 0;
    logic [39:0] m_acc [2];
    logic        m_sat [2];

    always #10 clk = ~clk;

    dual_acc_mac u_dual_acc_mac (
        .clk(clk), .rst(rst), .op_i(op_i), .acc_sel_i(acc_sel_i),
        .a_i(a_i), .b_i(b_i), .a_signed_i(a_signed_i), .b_signed_i(b_signed_i),
        .frac_i(frac_i), .acc_o(acc_o), .ovf_o(ovf_o), .sat_o(sat_o)
    );

    function automatic logic [39:0] f_prod(logic [15:0] a, logic [15:0] b,
                                           logic as, logic bs, logic fr);
        longint av = as ? longint'($signed(a)) : longint'(a);
        longint bv = bs ? longint'($signed(b)) : longint'(b);
        longint p  = av * bv;
        if (fr) p = p * 2;
        return p[39:0];
    endfunction

    function automatic logic f_oor(logic [39:0] v);
        return !(v[39:31] == 9'h000 || v[39:31] == 9'h1FF);
    endfunction

    task automatic check(string tag, logic [39:0] got, logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_state(string tag, int sel);
        check({tag, " R11 acc"}, acc_o, m_acc[sel]);
        check({tag, " R7 ovf"}, 40'(ovf_o), 40'(f_oor(m_acc[sel])));
        check({tag, " R9 sat"}, 40'(sat_o), 40'(m_sat[sel]));
    endtask

    task automatic model(int op, int sel, logic [39:0] p);
        case (op)
            1: begin m_acc[sel] = p; m_sat[sel] = 1'b0; end
            2: m_acc[sel] = m_acc[sel] + p;
            3: m_acc[sel] = m_acc[sel] - p;
            4: begin m_acc[sel] = '0; m_sat[sel] = 1'b0; end
            5: if (f_oor(m_acc[sel])) begin
                   m_acc[sel] = m_acc[sel][39] ? 40'hFF80000000 : 40'h007FFFFFFF;
                   m_sat[sel] = 1'b1;
               end
            default: ;
        endcase
    endtask

    task automatic apply(string tag, int op, int sel, logic [15:0] a, logic [15:0] b,
                         logic as, logic bs, logic fr);
        @(negedge clk);
        op_i = 3'(op); acc_sel_i = sel[0]; a_i = a; b_i = b;
        a_signed_i = as; b_signed_i = bs; frac_i = fr;
        @(posedge clk);
        #1;
        model(op, sel, f_prod(a, b, as, bs, fr));
        check_state(tag, sel);
    endtask

    task automatic peek(string tag, int sel);
        @(negedge clk);
        op_i = 3'd0; acc_sel_i = sel[0];
        #1;
        check_state(tag, sel);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; op_i = 3'd0; acc_sel_i = 1'b0; a_i = '0; b_i = '0;
        a_signed_i = 1'b0; b_signed_i = 1'b0; frac_i = 1'b0;
        m_acc[0] = '0; m_acc[1] = '0; m_sat[0] = 1'b0; m_sat[1] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset acc0", {acc_o[39:2], ovf_o, sat_o}, '0);
        acc_sel_i = 1'b1;
        #1;
        check("R1 reset acc1", {acc_o[39:2], ovf_o, sat_o}, '0);
        rst = 1'b0;

        apply("R2 signed -1*3", 1, 0, 16'hFFFF, 16'h0003, 1, 1, 0);
        check("R2 value", acc_o, 40'hFFFFFFFFFD);
        apply("R2 unsigned max", 1, 0, 16'hFFFF, 16'hFFFF, 0, 0, 0);
        check("R7 unsigned max overflows", 40'(ovf_o), 40'd1);
        apply("R2 mixed sign", 1, 1, 16'hFFFF, 16'hFFFF, 1, 0, 0);
        check("R2 mixed value", acc_o, 40'hFFFFFF0001);
        apply("R4 frac 0x8000 squared", 1, 1, 16'h8000, 16'h8000, 1, 1, 1);
        check("R4 frac value", acc_o, 40'h0080000000);
        apply("R4 frac half", 1, 1, 16'h4000, 16'h4000, 1, 1, 1);
        check("R4 frac half value", acc_o, 40'h0020000000);
        peek("R5 acc0 untouched", 0);
        apply("R3 add", 2, 1, 16'h0010, 16'h0010, 0, 0, 0);
        apply("R3 sub", 3, 1, 16'h7FFF, 16'h0002, 1, 1, 0);
        apply("R8 clamp positive", 5, 0, 16'h0, 16'h0, 0, 0, 0);
        check("R8 positive limit", acc_o, 40'h007FFFFFFF);
        apply("R9 add keeps sat", 2, 0, 16'h0001, 16'h0001, 0, 0, 0);
        check("R9 sat held", 40'(sat_o), 40'd1);
        apply("R10 code 6", 6, 0, 16'h1234, 16'h5678, 0, 0, 0);
        apply("R10 code 7", 7, 0, 16'h1234, 16'h5678, 0, 0, 0);
        apply("R9 load clears sat", 1, 0, 16'h0002, 16'h0003, 0, 0, 0);
        check("R9 sat cleared", 40'(sat_o), 40'd0);
        apply("R8 in-range clamp", 5, 0, 16'h0, 16'h0, 0, 0, 0);
        check("R8 unchanged", acc_o, 40'd6);
        apply("R6 clear", 4, 1, 16'h0, 16'h0, 0, 0, 0);
        apply("R3 sub negative", 3, 1, 16'hFFFF, 16'hFFFF, 0, 0, 0);
        apply("R8 clamp negative", 5, 1, 16'h0, 16'h0, 0, 0, 0);
        check("R8 negative limit", acc_o, 40'hFF80000000);
        apply("R6 clear sat", 4, 1, 16'h0, 16'h0, 0, 0, 0);
        for (int i = 0; i < 70; i++)
            apply("R12 R3 wrap chain", 2, 0, 16'hFFFF, 16'hFFFF, 0, 0, 1);
        peek("R5 acc1 after chain", 1);

        for (int i = 0; i < 3000; i++) begin
            int op = int'($urandom_range(0, 7));
            int sel = int'($urandom_range(0, 1));
            apply($sformatf("R2 R3 R5 random op %0d", op), op, sel,
                  16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            if (i % 16 == 0) peek("R5 random peek", 1 - sel);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule